// File: doc/BRIEF.md
# I2C Bus-Clear Command Sequencer

This block is a small command-driven engine that frees an I2C bus when a target keeps SDA pulled low. Software writes one command at a time. A read-data command clocks out nine SCL pulses with SDA left released: eight data slots and one acknowledge slot. The acknowledge slot stays high, so the target sees a NACK. The received bits are thrown away, and the block has no receive storage. A send-stop command produces a STOP condition. A single write can set both command bits. The block then runs the nine-pulse read and follows it at once with the STOP, which is the usual way to clear a stuck bus.

The block drives only open-drain enables: a 1 pulls the line low and a 0 releases it. Every phase lasts one programmable half-period, counted in clock cycles. A busy flag is high for the whole sequence. While the block is idle, it samples SDA through a synchronizer and reports a stuck-bus code whenever the line is low.

Top module: `i2c_bus_clear`

## Requirements
- R1: A write with `cmd_i[4]` set, accepted while idle, produces nine SCL pulses. Each pulse is a low half-period (`scl_oe_o`=1) followed by a high half-period (`scl_oe_o`=0), and `sda_oe_o` stays 0 for the whole command.
- R2: A write with only `cmd_i[2]` set, accepted while idle, produces three half-periods in order: SCL and SDA both pulled low, then SCL released with SDA still low, then both released.
- R3: A write with both `cmd_i[4]` and `cmd_i[2]` set runs the R1 read pattern and then the R2 stop pattern with no gap, for 21 half-periods in total.
- R4: `busy_o` rises in the cycle after an accepted write. It stays high for exactly (number of half-periods × effective half-period) cycles and then falls. Both line enables are 0 whenever `busy_o` is 0.
- R5: A write made while `busy_o` is 1 does not alter the running sequence. It sets `cmd_err_o` in the next cycle, and `cmd_err_o` stays set until reset.
- R6: A write while idle that has neither bit 4 nor bit 2 set is ignored: `busy_o` stays 0 and `cmd_err_o` is not set.
- R7: `state_o` shows 4'h9 during the read phases and 4'h3 during the stop phases. While idle it shows 4'hc if the synchronized SDA is low and 4'h0 if it is high. SDA passes through a two-stage synchronizer.
- R8: The half-period is captured when a command is accepted. Later changes on `half_period_i` do not affect the running command, and a value of 0 is treated as 1.
- R9: After reset, `busy_o`, `scl_oe_o`, `sda_oe_o` and `cmd_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle command write strobe |
| cmd_i | input | 8 | Command word; bit 4 = read-data, bit 2 = send-stop |
| half_period_i | input | 8 | Half-period length in clock cycles (0 acts as 1) |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Command in progress |
| cmd_err_o | output | 1 | Sticky flag: a write arrived while busy |
| state_o | output | 4 | Sequencer/bus state code |

## Verification
The hardest condition to reach is a command write that arrives in the middle of a running sequence. The sequence must continue exactly as if the write had never happened, and only the sticky error flag may change. The bench injects a send-stop write partway through a read, then keeps comparing every cycle of the line enables against the arithmetic schedule. The stuck-bus case is covered by holding SDA low both before and during a read. This shows that the 4'hc code appears only while the block is idle.

// File: rtl/i2c_bus_clear_pkg.sv
package i2c_bus_clear_pkg;
  typedef enum logic [1:0] {MODE_IDLE, MODE_READ, MODE_STOP} mode_e;
  localparam logic [3:0] CODE_IDLE  = 4'h0;
  localparam logic [3:0] CODE_STOP  = 4'h3;
  localparam logic [3:0] CODE_READ  = 4'h9;
  localparam logic [3:0] CODE_STUCK = 4'hc;
  localparam int unsigned STOP_PHASES = 3;
endpackage

// File: rtl/i2c_bus_clear_sync.sv
module i2c_bus_clear_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_clear_tick.sv
module i2c_bus_clear_tick #(
  parameter int unsigned HP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [HP_W-1:0] limit_i,
  output logic            tick_o
);
  localparam logic [HP_W-1:0] ONE = HP_W'(1);
  logic [HP_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == limit_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/i2c_bus_clear_fsm.sv
module i2c_bus_clear_fsm
  import i2c_bus_clear_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned HP_W      = 8,
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned RD_BIT    = 4,
  parameter int unsigned STOP_BIT  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [HP_W-1:0]  half_i,
  input  logic             tick_i,
  input  logic             sda_sync_i,
  output logic             busy_o,
  output logic [HP_W-1:0]  hp_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic [3:0]       state_o,
  output logic             err_o
);
  localparam int unsigned RD_PHASES = 2 * (DATA_BITS + 1);
  localparam int unsigned PH_RAW    = $clog2(RD_PHASES);
  localparam int unsigned PH_W      = (PH_RAW < 2) ? 2 : PH_RAW;
  localparam logic [PH_W-1:0] RD_LAST = PH_W'(RD_PHASES - 1);
  localparam logic [PH_W-1:0] ST_LAST = PH_W'(STOP_PHASES - 1);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

  mode_e           mode_q;
  logic [PH_W-1:0] ph_q;
  logic            stop_pend_q;
  logic [HP_W-1:0] hp_q;
  logic            err_q;

  logic want_rd, want_st, has_cmd, busy, accept;
  assign want_rd = cmd_i[RD_BIT];
  assign want_st = cmd_i[STOP_BIT];
  assign has_cmd = want_rd | want_st;
  assign busy    = (mode_q != MODE_IDLE);
  assign accept  = cmd_valid_i && !busy && has_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_IDLE;
      ph_q        <= '0;
      stop_pend_q <= 1'b0;
      hp_q        <= HP_W'(1);
      err_q       <= 1'b0;
    end else begin
      if (cmd_valid_i && busy) err_q <= 1'b1;
      unique case (mode_q)
        MODE_IDLE: begin
          if (accept) begin
            mode_q      <= want_rd ? MODE_READ : MODE_STOP;
            ph_q        <= '0;
            stop_pend_q <= want_rd && want_st;
            hp_q        <= (half_i == '0) ? HP_W'(1) : half_i;
          end
        end
        MODE_READ: begin
          if (tick_i) begin
            if (ph_q == RD_LAST) begin
              ph_q        <= '0;
              mode_q      <= stop_pend_q ? MODE_STOP : MODE_IDLE;
              stop_pend_q <= 1'b0;
            end else begin
              ph_q <= ph_q + PH_ONE;
            end
          end
        end
        MODE_STOP: begin
          if (tick_i) begin
            if (ph_q == ST_LAST) begin
              ph_q   <= '0;
              mode_q <= MODE_IDLE;
            end else begin
              ph_q <= ph_q + PH_ONE;
            end
          end
        end
        default: mode_q <= MODE_IDLE;
      endcase
    end
  end

  // read: even phase = SCL low, odd = released; stop: low/low, rel/low, rel/rel
  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    state_o  = sda_sync_i ? CODE_IDLE : CODE_STUCK;
    unique case (mode_q)
      MODE_READ: begin
        scl_oe_o = ~ph_q[0];
        state_o  = CODE_READ;
      end
      MODE_STOP: begin
        scl_oe_o = (ph_q == '0);
        sda_oe_o = (ph_q != ST_LAST);
        state_o  = CODE_STOP;
      end
      default: ;
    endcase
  end

  assign busy_o = busy;
  assign hp_o   = hp_q;
  assign err_o  = err_q;
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned HP_W        = 8,
  parameter int unsigned CMD_W       = 8,
  parameter int unsigned RD_BIT      = 4,
  parameter int unsigned STOP_BIT    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [HP_W-1:0]  half_period_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             cmd_err_o,
  output logic [3:0]       state_o
);
  logic sda_sync, tick, busy;
  logic [HP_W-1:0] hp;

  i2c_bus_clear_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_i),
    .q_o   (sda_sync)
  );

  i2c_bus_clear_tick #(.HP_W(HP_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .limit_i(hp),
    .tick_o (tick)
  );

  i2c_bus_clear_fsm #(
    .DATA_BITS(DATA_BITS),
    .HP_W     (HP_W),
    .CMD_W    (CMD_W),
    .RD_BIT   (RD_BIT),
    .STOP_BIT (STOP_BIT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_i),
    .half_i     (half_period_i),
    .tick_i     (tick),
    .sda_sync_i (sda_sync),
    .busy_o     (busy),
    .hp_o       (hp),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .state_o    (state_o),
    .err_o      (cmd_err_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
  parameter int unsigned CMD_W    = 8,
  parameter int unsigned RD_BIT   = 4,
  parameter int unsigned STOP_BIT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic             scl_oe_o,
  input logic             sda_oe_o,
  input logic             busy_o,
  input logic             cmd_err_o,
  input logic [3:0]       state_o
);
  logic has_cmd;
  assign has_cmd = cmd_i[RD_BIT] | cmd_i[STOP_BIT];

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R4
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && has_cmd) |=> busy_o); // R4
  AST_READ_SDA_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'h9) |-> !sda_oe_o); // R1
  AST_STOP_RELEASE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_oe_o); // R2
  AST_BUSY_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> cmd_err_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o); // R5
  AST_EMPTY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && !has_cmd) |=> !busy_o); // R6
  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && state_o != 4'h0) |-> (state_o == 4'hc)); // R7
  AST_BUSY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (state_o == 4'h9 || state_o == 4'h3)); // R7
endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(
  .CMD_W(CMD_W), .RD_BIT(RD_BIT), .STOP_BIT(STOP_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_i      (cmd_i),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .busy_o     (busy_o),
  .cmd_err_o  (cmd_err_o),
  .state_o    (state_o)
);

// File: tb/i2c_bus_clear_test.sv
module i2c_bus_clear_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_i = '0;
  logic [7:0] half_period_i = 8'd1;
  logic       sda_i = 1'b1;
  logic       scl_oe_o, sda_oe_o, busy_o, cmd_err_o;
  logic [3:0] state_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  exp_err = 1'b0;
  bit  done = 1'b0;

  always #2 clk_i = ~clk_i;

  i2c_bus_clear uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd_i),
    .half_period_i(half_period_i),
    .sda_i        (sda_i),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .busy_o       (busy_o),
    .cmd_err_o    (cmd_err_o),
    .state_o      (state_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input bit sda_lvl);
    check("R4 busy idle", busy_o, 0);
    check("R4 scl idle", scl_oe_o, 0);
    check("R4 sda idle", sda_oe_o, 0);
    check("R7 idle code", state_o, sda_lvl ? 0 : 12);
    check("R5 err idle", cmd_err_o, exp_err);
  endtask

  // run one command and compare every cycle against the schedule
  task automatic run(input logic [7:0] cmd, input int hp, input int inject_at, input bit sda_lvl);
    bit    rd = cmd[4];
    bit    st = cmd[2];
    int    heff = (hp == 0) ? 1 : hp;
    int    nph = (rd ? 18 : 0) + (st ? 3 : 0);
    int    total = nph * heff;
    int    pulses = 0;
    bit    prev = 1'b0;
    string tag = (rd && st) ? "R3" : (rd ? "R1" : "R2");
    @(negedge clk_i);
    half_period_i = 8'(hp);
    cmd_i = cmd;
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    half_period_i = 8'(hp + 7);
    for (int k = 0; k < total; k++) begin
      int  p = k / heff;
      bit  e_scl, e_sda;
      int  e_code;
      if (inject_at >= 0 && k == inject_at + 1) begin
        exp_err = 1'b1;
        cmd_valid_i = 1'b0;
      end
      if (rd && p < 18) begin
        e_scl = (p % 2 == 0); e_sda = 1'b0; e_code = 9;
      end else begin
        int q = p - (rd ? 18 : 0);
        e_scl = (q == 0); e_sda = (q < 2); e_code = 3;
      end
      check("R4 busy run", busy_o, 1);
      check({tag, "/R8 scl"}, scl_oe_o, e_scl);
      check({tag, " sda"}, sda_oe_o, e_sda);
      check("R7 run code", state_o, e_code);
      check("R5 err run", cmd_err_o, exp_err);
      if (scl_oe_o && !prev) pulses++;
      prev = scl_oe_o;
      if (k == inject_at) begin
        cmd_i = 8'h14;
        cmd_valid_i = 1'b1;
      end
      @(negedge clk_i);
    end
    check_idle(sda_lvl);
    check({tag, " pulse count"}, pulses, (rd ? 9 : 0) + (st ? 1 : 0));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 busy", busy_o, 0);
    check("R9 scl", scl_oe_o, 0);
    check("R9 sda", sda_oe_o, 0);
    check("R9 err", cmd_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle(1'b1);

    // R6 writes without command bits
    foreach (cmd_i[b]) ;
    cmd_i = 8'h01; cmd_valid_i = 1'b1;
    @(negedge clk_i); cmd_valid_i = 1'b0;
    check("R6 busy", busy_o, 0);
    cmd_i = 8'hEB; cmd_valid_i = 1'b1;
    @(negedge clk_i); cmd_valid_i = 1'b0;
    check("R6 busy", busy_o, 0);
    @(negedge clk_i);
    check("R6 err", cmd_err_o, 0);

    // R1 R2 R3 R8 sweep
    for (int h = 0; h < 6; h++) begin
      run(8'h10, h, -1, 1'b1);
      run(8'h04, h, -1, 1'b1);
      run(8'h14, h, -1, 1'b1);
    end
    run(8'hFF, 2, -1, 1'b1);

    // R7 stuck bus reported only while idle
    sda_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R7 stuck", state_o, 12);
    run(8'h10, 2, -1, 1'b0);
    sda_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R7 released", state_o, 0);

    // R5 write during busy
    run(8'h10, 2, 5, 1'b1);
    run(8'h04, 3, 2, 1'b1);
    repeat (4) @(negedge clk_i);
    check("R5 sticky", cmd_err_o, 1);

    rst_ni = 1'b0;
    @(negedge clk_i);
    exp_err = 1'b0;
    check("R9 err cleared", cmd_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle(1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule